// File: doc/BRIEF.md
# Voxel Triangle List Hit Tester

This block takes one ray that has reached one grid cell and walks that cell's list of triangle indices. The list starts at a given pointer and runs through consecutive entries until an entry of zero. For each non-zero index the block fetches a precomputed intersection record from a second memory. The record holds the barycentric coordinates u and v and the distance t, all signed fixed-point values. The block then tests the candidate and folds it into a running nearest-hit record (t, u, v, id).

The caller supplies three things on a start pulse: the list pointer, the far distance bound of the current cell, and the ray's hit record so far. A ray with no hit yet carries the largest positive t. Both memories answer a read with a fixed two-cycle latency. The walk issues one list read per cycle and keeps up to two triangle reads in flight.

At the end the block pulses `done` and presents the merged record with a flag. A set flag means some triangle in this cell was accepted and the ray moves on to shading. A clear flag means the ray goes back to grid traversal with its record untouched.

Top module: `voxel_hit_tester`

## Requirements
- R1: While reset is asserted and in the cycle after it, `done`, `listRd` and `triRd` are low.
- R2: After `start`, list reads go to `listPtr`, `listPtr`+1, ... on consecutive cycles (modulo 2^PTR_W). The walk ends at the first entry equal to 0. Entries fetched after that zero are never evaluated.
- R3: A candidate passes the barycentric test only if u >= 0, v >= 0 and u+v <= ONE, where ONE = 2^FRAC (u+v equal to ONE passes).
- R4: A candidate passes the depth test only if t >= 0 and t is strictly less than the t of the running record.
- R5: A candidate with t greater than the cell's far bound `tFar` is a miss. A candidate with t equal to `tFar` is accepted.
- R6: An accepted candidate replaces all four fields of the running record. Because of R4, the nearest accepted triangle is kept, and for equal t the one earlier in the list is kept.
- R7: `done` is a one-cycle pulse. With it, `hitFlag` is 1 exactly when at least one candidate was accepted. When `hitFlag` is 0, `hitOut` equals the `hitIn` given at start.
- R8: `hitIn` and `hitOut` pack t in the top W bits, then u, then v, with id in the low ID_W bits. t, u and v are two's complement.
- R9: A triangle read is issued only for a non-zero list entry, and its address equals that entry.
- R10: Memory data is taken two cycles after the address is presented (address sampled on one edge, data registered on the next, used in the cycle after).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk; sampled only while idle |
| listPtr | input | PTR_W | First list entry address |
| tFar | input | W | Far distance bound of the current cell |
| hitIn | input | 3*W+ID_W | Incoming hit record {t,u,v,id} |
| listRd | output | 1 | List memory read strobe |
| listAddr | output | PTR_W | List memory address |
| listData | input | ID_W | Triangle index returned by the list memory |
| triRd | output | 1 | Triangle record read strobe |
| triAddr | output | ID_W | Triangle record address (the index) |
| triU | input | W | Returned barycentric u |
| triV | input | W | Returned barycentric v |
| triT | input | W | Returned distance t |
| done | output | 1 | Walk complete pulse |
| hitFlag | output | 1 | Some candidate accepted in this cell |
| hitOut | output | 3*W+ID_W | Merged hit record {t,u,v,id} |

## Verification
The hardest state to reach is the end of a walk. There, the zero entry arrives while up to two triangle records are still in flight and further list reads have already gone out speculatively. The stimulus lays out lists of random length at random, wrapping pointers. Each list is followed by a trap index whose record would win. Random lists ending with one or two entries exercise the drain, and exact-boundary records (u+v equal to ONE, t equal to the far bound, t equal to the stored t, t of zero) probe the comparisons.

// File: rtl/voxel_hit_pkg.sv
package voxel_hit_pkg;

  typedef enum logic [1:0] {
    WALK_IDLE  = 2'd0,
    WALK_RUN   = 2'd1,
    WALK_DRAIN = 2'd2
  } walk_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture incoming record and far bound
    logic eval;   // a triangle record is on triU/triV/triT this cycle
  } walk_strobe_t;

endpackage

// File: rtl/voxel_hit_ctrl.sv
module voxel_hit_ctrl
  import voxel_hit_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int ID_W  = 8,
  parameter int LAT   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [PTR_W-1:0] listPtr,
  input  logic [ID_W-1:0]  listData,
  output logic             listRd,
  output logic [PTR_W-1:0] listAddr,
  output logic             triRd,
  output logic [ID_W-1:0]  triAddr,
  output walk_strobe_t     strb,
  output logic             done
);

  walk_state_t      state;
  logic [PTR_W-1:0] ptr;
  logic [LAT-1:0]   listPipe;
  logic [LAT-1:0]   triPipe;
  logic             entryArr;
  logic             isNull;

  always_comb begin
    listRd    = (state == WALK_RUN);
    listAddr  = ptr;
    entryArr  = (state == WALK_RUN) && listPipe[LAT-1];
    isNull    = (listData == '0);
    triRd     = entryArr && !isNull;
    triAddr   = listData;
    strb.load = (state == WALK_IDLE) && start;
    strb.eval = triPipe[LAT-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= WALK_IDLE;
      ptr      <= '0;
      listPipe <= '0;
      triPipe  <= '0;
      done     <= 1'b0;
    end else begin
      done     <= 1'b0;
      listPipe <= {listPipe[LAT-2:0], listRd};
      triPipe  <= {triPipe[LAT-2:0], triRd};
      unique case (state)
        WALK_IDLE: begin
          if (start) begin
            ptr   <= listPtr;
            state <= WALK_RUN;
          end
        end
        WALK_RUN: begin
          ptr <= ptr + 1'b1;
          if (entryArr && isNull) state <= WALK_DRAIN;
        end
        WALK_DRAIN: begin
          // the last in-flight record is evaluated in this cycle
          done  <= 1'b1;
          state <= WALK_IDLE;
        end
        default: state <= WALK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/voxel_hit_dpath.sv
module voxel_hit_dpath
  import voxel_hit_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 14,
  parameter int ID_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  walk_strobe_t          strb,
  input  logic [3*W+ID_W-1:0]   hitIn,
  input  logic [W-1:0]          tFar,
  input  logic [ID_W-1:0]       triId,
  input  logic [W-1:0]          triU,
  input  logic [W-1:0]          triV,
  input  logic [W-1:0]          triT,
  output logic                  anyHit,
  output logic [3*W+ID_W-1:0]   hitOut
);

  localparam int ONE_I = 1 << FRAC;
  localparam logic signed [W:0] ONE = (W+1)'(ONE_I);
  localparam int ID_PIPE = 2;

  logic signed [W-1:0] recT, recU, recV, farT;
  logic [ID_W-1:0]     recId;
  logic [ID_W-1:0]     idPipe [ID_PIPE];
  logic signed [W:0]   sumUV;
  logic                baryOk, depthOk, voxelOk, accept;

  always_comb begin
    sumUV   = $signed({triU[W-1], triU}) + $signed({triV[W-1], triV});
    baryOk  = !triU[W-1] && !triV[W-1] && (sumUV <= ONE);
    depthOk = !triT[W-1] && ($signed(triT) < recT);
    voxelOk = ($signed(triT) <= farT);
    accept  = strb.eval && baryOk && depthOk && voxelOk;
    hitOut  = {recT, recU, recV, recId};
  end

  // triangle index travels alongside the record read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ID_PIPE; i++) idPipe[i] <= '0;
    end else begin
      idPipe[0] <= triId;
      for (int i = 1; i < ID_PIPE; i++) idPipe[i] <= idPipe[i-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recT   <= '0;
      recU   <= '0;
      recV   <= '0;
      recId  <= '0;
      farT   <= '0;
      anyHit <= 1'b0;
    end else if (strb.load) begin
      recT   <= $signed(hitIn[3*W+ID_W-1 -: W]);
      recU   <= $signed(hitIn[2*W+ID_W-1 -: W]);
      recV   <= $signed(hitIn[W+ID_W-1 -: W]);
      recId  <= hitIn[ID_W-1:0];
      farT   <= $signed(tFar);
      anyHit <= 1'b0;
    end else if (accept) begin
      recT   <= $signed(triT);
      recU   <= $signed(triU);
      recV   <= $signed(triV);
      recId  <= idPipe[ID_PIPE-1];
      anyHit <= 1'b1;
    end
  end

endmodule

// File: rtl/voxel_hit_tester.sv
module voxel_hit_tester
  import voxel_hit_pkg::*;
#(
  parameter int W     = 16,
  parameter int FRAC  = 14,
  parameter int ID_W  = 8,
  parameter int PTR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [PTR_W-1:0]    listPtr,
  input  logic [W-1:0]        tFar,
  input  logic [3*W+ID_W-1:0] hitIn,
  output logic                listRd,
  output logic [PTR_W-1:0]    listAddr,
  input  logic [ID_W-1:0]     listData,
  output logic                triRd,
  output logic [ID_W-1:0]     triAddr,
  input  logic [W-1:0]        triU,
  input  logic [W-1:0]        triV,
  input  logic [W-1:0]        triT,
  output logic                done,
  output logic                hitFlag,
  output logic [3*W+ID_W-1:0] hitOut
);

  walk_strobe_t strb;

  voxel_hit_ctrl #(.PTR_W(PTR_W), .ID_W(ID_W), .LAT(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .listPtr(listPtr),
    .listData(listData), .listRd(listRd), .listAddr(listAddr),
    .triRd(triRd), .triAddr(triAddr), .strb(strb), .done(done)
  );

  voxel_hit_dpath #(.W(W), .FRAC(FRAC), .ID_W(ID_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .hitIn(hitIn), .tFar(tFar),
    .triId(triAddr), .triU(triU), .triV(triV), .triT(triT),
    .anyHit(hitFlag), .hitOut(hitOut)
  );

endmodule

// File: rtl/voxel_hit_checker.sv
module voxel_hit_checker #(
  parameter int W     = 16,
  parameter int ID_W  = 8,
  parameter int PTR_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic [W-1:0]        tFar,
  input logic [3*W+ID_W-1:0] hitIn,
  input logic                listRd,
  input logic [PTR_W-1:0]    listAddr,
  input logic                triRd,
  input logic [ID_W-1:0]     triAddr,
  input logic                done,
  input logic                hitFlag,
  input logic [3*W+ID_W-1:0] hitOut
);

  logic                busy;
  logic [3*W+ID_W-1:0] capIn;
  logic signed [W-1:0] capFar;
  logic signed [W-1:0] outT, capT;

  assign outT = $signed(hitOut[3*W+ID_W-1 -: W]);
  assign capT = $signed(capIn[3*W+ID_W-1 -: W]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      capIn  <= '0;
      capFar <= '0;
    end else if (!busy && start) begin
      busy   <= 1'b1;
      capIn  <= hitIn;
      capFar <= $signed(tFar);
    end else if (done) begin
      busy   <= 1'b0;
    end
  end

  p_quiet_reset_r1: assert property (@(posedge clk) !rstN |=> (!done && !listRd && !triRd));

  p_list_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (listRd && $past(listRd)) |-> (listAddr == PTR_W'($past(listAddr) + 1'b1)));

  p_depth_r4: assert property (@(posedge clk) disable iff (!rstN)
    (done && hitFlag) |-> (outT < capT && outT >= 0));

  p_voxel_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && hitFlag) |-> (outT <= capFar));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_miss_keeps_r7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !hitFlag) |-> (hitOut == capIn));

  p_no_null_fetch_r9: assert property (@(posedge clk) disable iff (!rstN)
    triRd |-> (triAddr != '0));

endmodule

bind voxel_hit_tester voxel_hit_checker #(.W(W), .ID_W(ID_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .tFar(tFar), .hitIn(hitIn),
  .listRd(listRd), .listAddr(listAddr), .triRd(triRd), .triAddr(triAddr),
  .done(done), .hitFlag(hitFlag), .hitOut(hitOut)
);

// File: tb/sim_voxel_hit_tester.sv
module sim_voxel_hit_tester;

  localparam int W = 16, FRAC = 14, ID_W = 8, PTR_W = 8;
  localparam int REC_W = 3*W + ID_W;
  localparam int ONE = 1 << FRAC;
  localparam int TMAX = (1 << (W-1)) - 1;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [PTR_W-1:0] listPtr = '0;
  logic [W-1:0] tFar = '0;
  logic [REC_W-1:0] hitIn = '0;
  logic listRd, triRd, done, hitFlag;
  logic [PTR_W-1:0] listAddr;
  logic [ID_W-1:0] listData, triAddr;
  logic [W-1:0] triU, triV, triT;
  logic [REC_W-1:0] hitOut;

  logic [ID_W-1:0] listMem [1 << PTR_W];
  logic [W-1:0] uMem [1 << ID_W];
  logic [W-1:0] vMem [1 << ID_W];
  logic [W-1:0] tMem [1 << ID_W];
  logic [ID_W-1:0] l1;
  logic [W-1:0] u1, v1, t1;

  int checks = 0, failures = 0, cycles = 0;
  int seqErr = 0, nullErr = 0;
  logic prevRd = 1'b0;
  logic [PTR_W-1:0] prevAddr = '0;

  always #2.5 clk = ~clk;

  voxel_hit_tester #(.W(W), .FRAC(FRAC), .ID_W(ID_W), .PTR_W(PTR_W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .listPtr(listPtr), .tFar(tFar),
    .hitIn(hitIn), .listRd(listRd), .listAddr(listAddr), .listData(listData),
    .triRd(triRd), .triAddr(triAddr), .triU(triU), .triV(triV), .triT(triT),
    .done(done), .hitFlag(hitFlag), .hitOut(hitOut)
  );

  // two-cycle memories (R10)
  always_ff @(posedge clk) begin
    l1 <= listMem[listAddr]; listData <= l1;
    u1 <= uMem[triAddr]; triU <= u1;
    v1 <= vMem[triAddr]; triV <= v1;
    t1 <= tMem[triAddr]; triT <= t1;
  end

  // port monitors for R2 and R9
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rstN) begin
      if (listRd && prevRd && listAddr != PTR_W'(prevAddr + 1'b1)) seqErr <= seqErr + 1;
      if (triRd && triAddr == '0) nullErr <= nullErr + 1;
    end
    prevRd <= listRd;
    prevAddr <= listAddr;
  end

  task automatic check(input bit ok, input string req, input logic [REC_W:0] act, input logic [REC_W:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [REC_W:0] refWalk(input logic [PTR_W-1:0] p, input int far, input logic [REC_W-1:0] rin);
    int rt, uu, vv, tt;
    logic [REC_W-1:0] r;
    logic flag;
    r = rin; flag = 1'b0;
    for (int k = 0; k < (1 << PTR_W); k++) begin
      logic [ID_W-1:0] id;
      id = listMem[PTR_W'(p + k)];
      if (id == '0) break;
      rt = $signed(r[REC_W-1 -: W]);
      uu = $signed(uMem[id]); vv = $signed(vMem[id]); tt = $signed(tMem[id]);
      if (uu >= 0 && vv >= 0 && uu + vv <= ONE && tt >= 0 && tt < rt && tt <= far) begin
        r = {tMem[id], uMem[id], vMem[id], id};
        flag = 1'b1;
      end
    end
    return {flag, r};
  endfunction

  function automatic logic [REC_W-1:0] mkRec(input int t, input int u, input int v, input int id);
    return {W'(t), W'(u), W'(v), ID_W'(id)};
  endfunction

  task automatic runWalk(input logic [PTR_W-1:0] p, input int far, input logic [REC_W-1:0] rin,
                         input string req, output logic [REC_W:0] got);
    logic [REC_W:0] exp;
    int wait_n;
    exp = refWalk(p, far, rin);
    @(negedge clk);
    listPtr = p; tFar = W'(far); hitIn = rin; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_n = 0;
    while (!done && wait_n < 600) begin @(negedge clk); wait_n++; end
    got = {hitFlag, hitOut};
    check(done == 1'b1, "R7 done arrives", {REC_W'(0), done}, {REC_W'(0), 1'b1});
    check(got == exp, req, got, exp);
    @(negedge clk);
    check(done == 1'b0, "R7 done single cycle", {REC_W'(0), done}, {REC_W'(0), 1'b0});
  endtask

  task automatic clearMem();
    for (int i = 0; i < (1 << PTR_W); i++) listMem[i] = '0;
    for (int i = 0; i < (1 << ID_W); i++) begin uMem[i] = '0; vMem[i] = '0; tMem[i] = W'(TMAX); end
  endtask

  task automatic setTri(input int id, input int u, input int v, input int t);
    uMem[id] = W'(u); vMem[id] = W'(v); tMem[id] = W'(t);
  endtask

  initial begin
    logic [REC_W:0] got;
    logic [REC_W-1:0] noHit;
    void'($urandom(1234));
    clearMem();
    noHit = mkRec(TMAX, 0, 0, 0);
    repeat (3) @(negedge clk);
    check(!done && !listRd && !triRd, "R1 reset outputs", {REC_W'(0), done}, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !listRd && !triRd, "R1 idle after reset", {REC_W'(0), listRd}, '0);

    // R2 empty list: miss, record unchanged (R7)
    runWalk(8'd10, 1000, mkRec(500, 3, 4, 9), "R2 R7 empty list", got);

    // R3 R5 R8 boundary acceptance
    setTri(5, ONE, 0, 700);
    listMem[20] = 8'd5; listMem[21] = '0;
    runWalk(8'd20, 700, noHit, "R3 R5 u+v=ONE t=tFar", got);
    check(got[REC_W-1 -: W] == W'(700) && got[ID_W-1:0] == 8'd5 && got[2*W+ID_W-1 -: W] == W'(ONE),
          "R8 field order", got, {1'b1, mkRec(700, ONE, 0, 5)});

    // R3 negative u / u+v over ONE rejected
    setTri(6, -1, 10, 50); setTri(7, ONE/2 + 1, ONE/2, 40);
    listMem[30] = 8'd6; listMem[31] = 8'd7; listMem[32] = '0;
    runWalk(8'd30, 1000, noHit, "R3 barycentric rejects", got);
    check(got[REC_W] == 1'b0, "R3 no hit flag", got, {1'b0, noHit});

    // R4 t equal to stored, negative t rejected; t=0 accepted
    setTri(8, 10, 10, 300); setTri(9, 10, 10, -1); setTri(10, 20, 20, 0);
    listMem[40] = 8'd8; listMem[41] = 8'd9; listMem[42] = '0;
    runWalk(8'd40, 1000, mkRec(300, 1, 1, 1), "R4 equal and negative t", got);
    listMem[42] = 8'd10; listMem[43] = '0;
    runWalk(8'd40, 1000, mkRec(300, 1, 1, 1), "R4 zero t accepted", got);

    // R5 beyond cell bound
    setTri(11, 5, 5, 701);
    listMem[50] = 8'd11; listMem[51] = '0;
    runWalk(8'd50, 700, noHit, "R5 t beyond tFar", got);

    // R6 ties keep first, nearer later replaces; R2 trap after null, wrap
    setTri(12, 1, 1, 200); setTri(13, 2, 2, 200); setTri(14, 3, 3, 150); setTri(15, 0, 0, 1);
    listMem[254] = 8'd12; listMem[255] = 8'd13; listMem[0] = 8'd14; listMem[1] = '0; listMem[2] = 8'd15;
    runWalk(8'd254, 1000, noHit, "R6 R2 nearest, wrap, trap after null", got);
    listMem[0] = '0;
    runWalk(8'd254, 1000, noHit, "R6 tie keeps first", got);
    check(got[ID_W-1:0] == 8'd12, "R6 tie id", got, {1'b1, mkRec(200, 1, 1, 12)});

    // random walks
    for (int run = 0; run < 300; run++) begin
      int len, far;
      logic [PTR_W-1:0] p;
      logic [REC_W-1:0] rin;
      for (int i = 1; i < (1 << ID_W); i++)
        setTri(i, int'($urandom_range(0, ONE + ONE/4)) - ONE/8,
                  int'($urandom_range(0, ONE + ONE/4)) - ONE/8,
                  int'($urandom_range(0, 3000)) - 200);
      for (int i = 0; i < (1 << PTR_W); i++) listMem[i] = ID_W'($urandom_range(1, 255));
      len = $urandom_range(0, 12);
      p = PTR_W'($urandom);
      listMem[PTR_W'(p + len)] = '0;
      far = $urandom_range(300, 3000);
      rin = ($urandom_range(0, 1) == 1) ? noHit
            : mkRec($urandom_range(100, 3000), $urandom_range(0, 999), $urandom_range(0, 999), $urandom_range(1, 255));
      runWalk(p, far, rin, "R3 R4 R5 R6 R7 random walk", got);
    end

    check(seqErr == 0, "R2 consecutive list addresses", {REC_W'(0), 1'b0} + seqErr, '0);
    check(nullErr == 0, "R9 no fetch of null entry", {REC_W'(0), 1'b0} + nullErr, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++; failures++;
    $display("FAIL watchdog R7 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule